// File: doc/BRIEF.md
# Column Output Port Arbiter

This block sits at one output port of a tiled high-radix router. Every subswitch in the port's column has a private column buffer that feeds this port, so the port sees eight separate flit sources. The block carries out the second, per-port stage of output arbitration. It picks one source whose head flit is waiting and passes that packet's flits to the output link until the tail flit has gone. Only then does it choose again. Because each port has its own arbiter, the choice is local and no shared central arbiter is involved.

Flits move under wormhole rules. A grant is taken when a head flit is presented and is kept until that packet's tail flit is accepted downstream. Flits of different packets never interleave on the output. Sources take turns in round-robin order. The search starts from a pointer that moves one place past the source that last finished a packet. The flit path from the granted source to the output is combinational. The only state is the grant (a lock flag and an owner index) and the round-robin pointer.

Each source and the output use a valid/ready handshake. A flit carries a data word plus head and tail markers. A flit with both markers set is a one-flit packet.

Top module: `col_port_arb`

## Requirements
- R1: While reset is high and for the first cycle after it, with no source valid, `out_valid` is 0 and every bit of `src_ready` is 0. The round-robin pointer starts at source 0.
- R2: When no grant is held, the winner is the first source, searching upward from the pointer and wrapping from source 7 to source 0, that has `src_valid` and `src_head` both 1. When a packet's tail flit is accepted, the pointer becomes the winner index plus one, modulo 8.
- R3: Once a source's head flit has been presented on the output, that source keeps the grant until its tail flit is accepted. No flit from another source appears on the output in between.
- R4: A flit is transferred only in a cycle where the granted source's `src_valid` and `out_ready` are both 1. `src_ready` is one-hot or zero, and only the granted source's bit equals `out_ready`.
- R5: `out_data`, `out_head` and `out_tail` equal the granted source's `src_data` slice (bits `s*DATA_W` upward for source `s`), `src_head` and `src_tail` in the same cycle.
- R6: When no grant is held and no source presents a valid head flit, `out_valid` and `src_ready` are 0. A valid flit with `src_head` = 0 from a source that holds no grant is not forwarded.
- R7: A flit with both `src_head` and `src_tail` set is granted and released in the cycle it is accepted. A different source can be granted and accepted in the very next cycle.
- R8: While a presented head flit waits with `out_ready` low, the selected source does not change, even if a source with higher round-robin priority becomes valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | N_SRC | Per-source flit valid |
| src_head | input | N_SRC | Per-source head-flit marker |
| src_tail | input | N_SRC | Per-source tail-flit marker |
| src_data | input | N_SRC*DATA_W | Per-source flit data, source s at bits s*DATA_W upward |
| src_ready | output | N_SRC | Per-source accept, asserted only toward the granted source |
| out_valid | output | 1 | Output flit valid |
| out_head | output | 1 | Output head-flit marker |
| out_tail | output | 1 | Output tail-flit marker |
| out_data | output | DATA_W | Output flit data |
| out_ready | input | 1 | Output link accepts a flit |

## Verification
A wrong pointer shows up at the first contended choice: the output presents a different source's data than the round-robin order predicts, in that same cycle. A lock that is released too early shows a foreign head flit in the middle of a packet. A lock that sticks shows `out_valid` held low, or `src_ready` routed to a finished source, in the cycle after the tail. The bench compares `out_valid`, `src_ready` and the output flit against a behavioural model on every clock, so any wrong grant state is reported in the first cycle it affects the ports.

// File: rtl/col_arb_pkg.sv
package col_arb_pkg;

  // Round-robin wrap of an index into the range [0, n).
  function automatic int unsigned rr_wrap(input int unsigned v, input int unsigned n);
    return v % n;
  endfunction

endpackage

// File: rtl/cpa_rr_pick.sv
module cpa_rr_pick
  import col_arb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Scan from base upward with wrap; first requester wins.
  always_comb begin
    found = 1'b0;
    idx   = base;
    for (int k = 0; k < N; k++) begin
      if (!found && req[rr_wrap(int'(base) + k, N)]) begin
        found = 1'b1;
        idx   = IW'(rr_wrap(int'(base) + k, N));
      end
    end
  end

endmodule

// File: rtl/cpa_flit_mux.sv
module cpa_flit_mux #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int IW = 3
) (
  input  logic [N*DW-1:0] in_data,
  input  logic [N-1:0]    in_head,
  input  logic [N-1:0]    in_tail,
  input  logic [IW-1:0]   sel,
  output logic [DW-1:0]   o_data,
  output logic            o_head,
  output logic            o_tail
);

  logic [DW-1:0] lane [N];

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane[g] = in_data[g*DW +: DW];
  end

  assign o_data = lane[sel];
  assign o_head = in_head[sel];
  assign o_tail = in_tail[sel];

endmodule

// File: rtl/cpa_grant_ctrl.sv
module cpa_grant_ctrl
  import col_arb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cand_found,
  input  logic [IW-1:0] cand_idx,
  input  logic          sel_valid,
  input  logic          sel_tail,
  input  logic          out_ready,
  output logic          grant_active,
  output logic [IW-1:0] sel,
  output logic [IW-1:0] ptr,
  output logic          locked
);

  logic [IW-1:0] owner;
  logic          xfer;
  logic          done;

  assign sel          = locked ? owner : cand_idx;
  assign grant_active = locked | cand_found;
  assign xfer         = grant_active & sel_valid & out_ready;
  assign done         = xfer & sel_tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      owner  <= '0;
      ptr    <= '0;
    end else if (grant_active) begin
      if (done) begin
        locked <= 1'b0;
        ptr    <= IW'(rr_wrap(int'(sel) + 1, N));
      end else begin
        locked <= 1'b1;
        owner  <= sel;
      end
    end
  end

endmodule

// File: rtl/col_port_arb.sv
module col_port_arb #(
  parameter int N_SRC  = 8,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        src_valid,
  input  logic [N_SRC-1:0]        src_head,
  input  logic [N_SRC-1:0]        src_tail,
  input  logic [N_SRC*DATA_W-1:0] src_data,
  output logic [N_SRC-1:0]        src_ready,
  output logic                    out_valid,
  output logic                    out_head,
  output logic                    out_tail,
  output logic [DATA_W-1:0]       out_data,
  input  logic                    out_ready
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] head_req;
  logic             cand_found;
  logic [IDX_W-1:0] cand_idx;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] sel;
  logic             grant_active;
  logic             locked;

  assign head_req = src_valid & src_head;

  cpa_rr_pick #(.N(N_SRC), .IW(IDX_W)) u_pick (
    .req   (head_req),
    .base  (ptr),
    .found (cand_found),
    .idx   (cand_idx)
  );

  cpa_grant_ctrl #(.N(N_SRC), .IW(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cand_found   (cand_found),
    .cand_idx     (cand_idx),
    .sel_valid    (src_valid[sel]),
    .sel_tail     (src_tail[sel]),
    .out_ready    (out_ready),
    .grant_active (grant_active),
    .sel          (sel),
    .ptr          (ptr),
    .locked       (locked)
  );

  cpa_flit_mux #(.N(N_SRC), .DW(DATA_W), .IW(IDX_W)) u_mux (
    .in_data (src_data),
    .in_head (src_head),
    .in_tail (src_tail),
    .sel     (sel),
    .o_data  (out_data),
    .o_head  (out_head),
    .o_tail  (out_tail)
  );

  assign out_valid = grant_active & src_valid[sel];

  for (genvar g = 0; g < N_SRC; g++) begin : g_rdy
    assign src_ready[g] = grant_active & out_ready & (sel == IDX_W'(g));
  end

endmodule

// File: rtl/cpa_checker.sv
module cpa_checker #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  src_valid,
  input logic [N-1:0]  src_head,
  input logic [N-1:0]  src_ready,
  input logic          out_valid,
  input logic          out_head,
  input logic          out_tail,
  input logic          out_ready,
  input logic [IW-1:0] sel
);

  // Packet-in-flight tracker, built only from the output handshake.
  logic in_pkt;
  always_ff @(posedge clk) begin
    if (rst) in_pkt <= 1'b0;
    else if (out_valid && out_ready) in_pkt <= !out_tail;
  end

  p_ready_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ready));

  p_no_ready_when_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> (src_ready == '0));

  p_xfer_from_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> ((src_valid & src_ready) != '0));

  p_no_interleave_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_head) |-> !in_pkt);

  p_hold_sel_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (sel == $past(sel)));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!in_pkt && ((src_valid & src_head) == '0)) |-> !out_valid);

endmodule

bind col_port_arb cpa_checker #(.N(N_SRC), .IW(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_valid (src_valid),
  .src_head  (src_head),
  .src_ready (src_ready),
  .out_valid (out_valid),
  .out_head  (out_head),
  .out_tail  (out_tail),
  .out_ready (out_ready),
  .sel       (sel)
);

// File: tb/sim_col_port_arb.sv
module sim_col_port_arb;

  localparam int NS = 8;
  localparam int DW = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NS-1:0]    src_valid = '0, src_head = '0, src_tail = '0, src_ready;
  logic [NS*DW-1:0] src_data = '0;
  logic             out_valid, out_head, out_tail, out_ready = 1'b0;
  logic [DW-1:0]    out_data;

  always #4 clk = ~clk;

  col_port_arb #(.N_SRC(NS), .DATA_W(DW)) u0 (.*);

  typedef struct { logic [DW-1:0] d; bit h; bit t; } fl_t;
  fl_t q [NS][$];
  int  xlog [$];
  int  seq = 0;
  int  nchk = 0, nerr = 0;
  bit [NS-1:0] gate = '1;
  bit  m_locked = 0;
  int  m_owner = 0, m_ptr = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_pkt(int s, int len);
    for (int i = 0; i < len; i++) begin
      fl_t f;
      f.d = {4'(s), 12'(seq)};
      f.h = (i == 0);
      f.t = (i == len - 1);
      seq++;
      q[s].push_back(f);
    end
  endtask

  // One clock: drive, compare against the behavioural model, then advance it.
  task automatic cyc(bit rdy);
    bit found, active, ev, xfer;
    int sel;
    logic [NS-1:0] er;
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      src_valid[s] = (q[s].size() > 0) && gate[s];
      src_head[s]  = (q[s].size() > 0) ? q[s][0].h : 1'b0;
      src_tail[s]  = (q[s].size() > 0) ? q[s][0].t : 1'b0;
      src_data[s*DW +: DW] = (q[s].size() > 0) ? q[s][0].d : '0;
    end
    out_ready = rdy;
    #1;
    found = 0; sel = 0;
    if (m_locked) sel = m_owner;
    else
      for (int k = 0; k < NS; k++) begin
        int j = (m_ptr + k) % NS;
        if (!found && src_valid[j] && src_head[j]) begin found = 1; sel = j; end
      end
    active = m_locked || found;
    ev = active && src_valid[sel];
    er = '0;
    if (active && rdy) er[sel] = 1'b1;
    chk(out_valid == ev, "R6", "out_valid", out_valid, ev);
    chk(src_ready == er, "R4", "src_ready", src_ready, er);
    if (ev) begin
      chk(out_data == q[sel][0].d, "R5", "out_data", out_data, q[sel][0].d);
      chk(out_head == q[sel][0].h && out_tail == q[sel][0].t, "R5", "markers",
          {out_head, out_tail}, {q[sel][0].h, q[sel][0].t});
    end
    xfer = ev && rdy;
    if (active) begin
      if (xfer && q[sel][0].t) begin
        m_locked = 0;
        m_ptr = (sel + 1) % NS;
      end else begin
        m_locked = 1;
        m_owner = sel;
      end
    end
    if (xfer) begin
      xlog.push_back(sel);
      void'(q[sel].pop_front());
    end
  endtask

  task automatic chk_log(string req, int exp[$]);
    chk(xlog.size() == exp.size(), req, "transfer count", xlog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < xlog.size(); i++)
      chk(xlog[i] == exp[i], req, "winner order", xlog[i], exp[i]);
    xlog.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(src_ready == '0, "R1", "src_ready in reset", src_ready, 0);
    rst = 1'b0;
    cyc(1);
    chk(xlog.size() == 0, "R1", "idle after reset", xlog.size(), 0);

    // R2 / R7: all sources single-flit, back to back in pointer order
    for (int s = 0; s < NS; s++) add_pkt(s, 1);
    repeat (NS) cyc(1);
    chk_log("R7", '{0, 1, 2, 3, 4, 5, 6, 7});

    // R2: pointer moves past the last winner, with wrap
    add_pkt(1, 1); add_pkt(5, 1);
    repeat (2) cyc(1);
    chk_log("R2", '{1, 5});
    add_pkt(0, 1); add_pkt(6, 1);
    repeat (2) cyc(1);
    chk_log("R2", '{6, 0});

    // R8: blocked head keeps selection; R3: packet not interleaved
    add_pkt(2, 3); add_pkt(4, 1);
    cyc(0);
    add_pkt(1, 1);
    repeat (3) begin
      cyc(0);
      chk(out_data[15:12] == 4'd2, "R8", "held source", out_data[15:12], 2);
    end
    repeat (5) cyc(1);
    chk_log("R3", '{2, 2, 2, 4, 1});

    // R6: body flit from an ungranted source is ignored
    begin
      fl_t f;
      f.d = 16'h3abc; f.h = 0; f.t = 1;
      q[3].push_back(f);
    end
    repeat (3) begin
      cyc(1);
      chk(out_valid == 1'b0 && src_ready == '0, "R6", "stray body flit",
          {out_valid, src_ready}, 0);
    end
    q[3].delete();
    xlog.delete();

    // Random traffic with bubbles and backpressure
    for (int c = 0; c < 3000; c++) begin
      for (int s = 0; s < NS; s++)
        if (q[s].size() == 0 && ($urandom % 8) == 0) add_pkt(s, 1 + ($urandom % 5));
      gate = NS'($urandom) | NS'($urandom);
      cyc(($urandom % 10) < 7);
    end

    // Drain: every source must be served
    gate = '1;
    for (int c = 0; c < 400; c++) cyc(1);
    for (int s = 0; s < NS; s++)
      chk(q[s].size() == 0, "R2", "source drained", q[s].size(), 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule